// File: doc/BRIEF.md
# Vector Memory Lane Formatter

This block sits between a load/store unit and a vector register made of sixteen 32-bit lanes. Each request carries an operation code, an effective address, the 64-byte memory line that holds the access, and the register contents to store. For loads it picks the block out of the line and widens each narrow element to a full lane. Byte and half-word elements are sign- or zero-extended as the code selects. An eight-word load fills only the low half of the lanes and writes zero to the rest. For stores it takes the low byte or half-word of every lane and packs them into a contiguous block. It places that block at the access offset inside the line and sets one byte enable per written byte.

The memory line is little-endian, with lane 0 at the lowest address. An access must be aligned to its total size: 16 bytes for byte vectors, 32 bytes for half-word vectors and eight-word loads, and 64 bytes for full-width transfers. A misaligned address raises a trap flag for the load/store unit and suppresses all data and enables. Results are registered and appear one clock after the request.

Top module: `vlane_fmt`

## Requirements
- R1: While reset is held, and in the first cycle after it, out_valid, out_misalign, out_be, out_wdata and out_lanes are all zero.
- R2: A request with a recognised code (7, 8, 9, 11, 12, 13, 36, 37, 38) gives out_valid high in the cycle after it is accepted. Any other code gives no out_valid. Whenever out_valid is low, every other output is zero.
- R3: Code 9 (full load, 64-byte aligned) returns the whole line unchanged on out_lanes.
- R4: Code 7 loads 16 bytes starting at line byte addr[5:0]. Byte i is sign-extended into lane i (out_lanes bits 32i+31:32i).
- R5: Code 11 loads 16 bytes the same way as code 7 but zero-extends each one.
- R6: Codes 8 (sign) and 12 (zero) load 16 half-words starting at line byte addr[5:0]. Half-word i is extended into lane i.
- R7: Code 13 loads 8 words starting at line byte addr[5:0] into lanes 0..7 and writes zero to lanes 8..15.
- R8: Code 36 writes bits 32i+7:32i of store_reg to line byte addr[5:0]+i for i=0..15. It sets out_be only for those 16 bytes, and every other byte of out_wdata is zero.
- R9: Code 37 writes bits 32i+15:32i of store_reg to line bytes addr[5:0]+2i and +2i+1, with out_be set only for those 32 bytes.
- R10: Code 38 (64-byte aligned) copies store_reg to out_wdata with all 64 byte enables set.
- R11: If addr modulo the access size (16, 32 or 64 bytes) is non-zero, out_misalign is 1 and out_lanes, out_wdata and out_be are all zero.
- R12: A load gives zero out_be and out_wdata. A store gives zero out_lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 6 | Operation code |
| req_addr | input | ADDR_W (32) | Effective byte address |
| mem_line | input | LANES*LANE_W (512) | Memory line holding a load access |
| store_reg | input | LANES*LANE_W (512) | Vector register contents for a store |
| out_valid | output | 1 | Result present |
| out_misalign | output | 1 | Alignment trap for the load/store unit |
| out_lanes | output | LANES*LANE_W (512) | Formatted load lanes |
| out_wdata | output | LANES*LANE_W (512) | Store data placed in the line |
| out_be | output | LANES*LANE_W/8 (64) | Store byte enables |

## Verification
Every result is captured by a single output register, so a request driven on a falling edge is taken at the next rising edge. Its results are read at the falling edge that follows. Each scenario task drives one request for one cycle, drops req_valid, and samples in that window. The next request therefore cannot overlap, and the task then sees the idle cycle after it.

// File: rtl/vlf_pkg.sv
package vlf_pkg;

   typedef enum logic [2:0] {
      K_NONE,
      K_LD8,
      K_LD16,
      K_LDW,
      K_LDHALF,
      K_ST8,
      K_ST16,
      K_STW
   } vlf_kind_e;

   localparam logic [5:0] OP_LD_S8  = 6'd7;
   localparam logic [5:0] OP_LD_S16 = 6'd8;
   localparam logic [5:0] OP_LD_W   = 6'd9;
   localparam logic [5:0] OP_LD_U8  = 6'd11;
   localparam logic [5:0] OP_LD_U16 = 6'd12;
   localparam logic [5:0] OP_LD_HW  = 6'd13;
   localparam logic [5:0] OP_ST_8   = 6'd36;
   localparam logic [5:0] OP_ST_16  = 6'd37;
   localparam logic [5:0] OP_ST_W   = 6'd38;

endpackage

// File: rtl/vlf_decode.sv
module vlf_decode
   import vlf_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int LANE_W = 32
) (
   input  logic [5:0]                     op,
   output vlf_kind_e                      kind,
   output logic                           sext,
   output logic                           is_store,
   output logic [$clog2(LANES*LANE_W/8):0] nbytes
);
   localparam int LINE_B = LANES * LANE_W / 8;
   localparam int NB_W   = $clog2(LINE_B) + 1;

   always_comb begin
      kind = K_NONE;
      sext = 1'b0;
      unique case (op)
         OP_LD_S8:  begin kind = K_LD8;  sext = 1'b1; end
         OP_LD_U8:  kind = K_LD8;
         OP_LD_S16: begin kind = K_LD16; sext = 1'b1; end
         OP_LD_U16: kind = K_LD16;
         OP_LD_W:   kind = K_LDW;
         OP_LD_HW:  kind = K_LDHALF;
         OP_ST_8:   kind = K_ST8;
         OP_ST_16:  kind = K_ST16;
         OP_ST_W:   kind = K_STW;
         default:   kind = K_NONE;
      endcase
   end

   assign is_store = (kind == K_ST8) || (kind == K_ST16) || (kind == K_STW);

   always_comb begin
      unique case (kind)
         K_LD8, K_ST8:   nbytes = NB_W'(LANES);
         K_LD16, K_ST16: nbytes = NB_W'(2 * LANES);
         K_LDHALF:       nbytes = NB_W'(LINE_B / 2);
         K_LDW, K_STW:   nbytes = NB_W'(LINE_B);
         default:        nbytes = '0;
      endcase
   end
endmodule

// File: rtl/vlf_unpack.sv
module vlf_unpack
   import vlf_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int LANE_W = 32
) (
   input  logic [LANES*LANE_W-1:0]              line,
   input  logic [$clog2(LANES*LANE_W/8)-1:0]    off,
   input  vlf_kind_e                            kind,
   input  logic                                 sext,
   output logic [LANES*LANE_W-1:0]              lanes
);
   localparam int LINE_W = LANES * LANE_W;

   logic [LINE_W-1:0] src;
   assign src = line >> {off, 3'b000};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0]        b;
      logic [15:0]       h;
      logic [LANE_W-1:0] w;
      logic [LANE_W-1:0] hw;
      logic [LANE_W-1:0] v;

      assign b = src[8*i +: 8];
      assign h = src[16*i +: 16];
      assign w = src[LANE_W*i +: LANE_W];

      if (i < LANES / 2) begin : g_low
         assign hw = w;
      end else begin : g_high
         assign hw = '0;
      end

      always_comb begin
         unique case (kind)
            K_LD8:    v = {{(LANE_W-8){sext & b[7]}}, b};
            K_LD16:   v = {{(LANE_W-16){sext & h[15]}}, h};
            K_LDW:    v = w;
            K_LDHALF: v = hw;
            default:  v = '0;
         endcase
      end

      assign lanes[LANE_W*i +: LANE_W] = v;
   end

   // R7: an eight-word load never leaves data in the upper lanes
   always_comb begin
      if (kind == K_LDHALF)
         p_half_upper_zero_r7: assert (lanes[LINE_W-1:LINE_W/2] == '0);
   end
endmodule

// File: rtl/vlf_pack.sv
module vlf_pack
   import vlf_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int LANE_W = 32
) (
   input  logic [LANES*LANE_W-1:0]            vreg,
   input  logic [$clog2(LANES*LANE_W/8)-1:0]  off,
   input  vlf_kind_e                          kind,
   input  logic [$clog2(LANES*LANE_W/8):0]    nbytes,
   output logic [LANES*LANE_W-1:0]            wdata,
   output logic [LANES*LANE_W/8-1:0]          be
);
   localparam int LINE_W = LANES * LANE_W;
   localparam int LINE_B = LINE_W / 8;
   localparam int NB_W   = $clog2(LINE_B) + 1;

   logic [LINE_W-1:0] p8, p16, sel;
   logic [LINE_B-1:0] ones;

   assign p8[LINE_W-1:8*LANES]   = '0;
   assign p16[LINE_W-1:16*LANES] = '0;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign p8[8*i +: 8]   = vreg[LANE_W*i +: 8];
      assign p16[16*i +: 16] = vreg[LANE_W*i +: 16];
   end

   always_comb begin
      unique case (kind)
         K_ST8:   sel = p8;
         K_ST16:  sel = p16;
         K_STW:   sel = vreg;
         default: sel = '0;
      endcase
   end

   assign ones  = '1;
   assign wdata = sel << {off, 3'b000};
   assign be    = (kind == K_ST8 || kind == K_ST16 || kind == K_STW)
                  ? (ones >> (NB_W'(LINE_B) - nbytes)) << off : '0;

   // R8: an aligned store enables exactly as many bytes as it writes
   always_comb begin
      if ((kind == K_ST8 || kind == K_ST16 || kind == K_STW) &&
          (({1'b0, off} & (nbytes - 1'b1)) == '0))
         p_be_size_r8: assert ($countones(be) == int'(nbytes));
   end
endmodule

// File: rtl/vlane_fmt.sv
module vlane_fmt
   import vlf_pkg::*;
#(
   parameter int LANES  = 16,
   parameter int LANE_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             req_valid,
   input  logic [5:0]                       req_op,
   input  logic [ADDR_W-1:0]                req_addr,
   input  logic [LANES*LANE_W-1:0]          mem_line,
   input  logic [LANES*LANE_W-1:0]          store_reg,
   output logic                             out_valid,
   output logic                             out_misalign,
   output logic [LANES*LANE_W-1:0]          out_lanes,
   output logic [LANES*LANE_W-1:0]          out_wdata,
   output logic [LANES*LANE_W/8-1:0]        out_be
);
   localparam int LINE_W = LANES * LANE_W;
   localparam int LINE_B = LINE_W / 8;
   localparam int OFF_W  = $clog2(LINE_B);

   if (LANE_W < 32 || (LANE_W % 16) != 0) begin : g_bad_lane
      $error("vlane_fmt: LANE_W must be a multiple of 16 and at least 32");
   end
   if (LANES < 2 || (LANES % 2) != 0) begin : g_bad_lanes
      $error("vlane_fmt: LANES must be even and at least 2");
   end
   if (ADDR_W < OFF_W) begin : g_bad_addr
      $error("vlane_fmt: ADDR_W narrower than the line offset");
   end

   vlf_kind_e         kind;
   logic              sext, is_store, mis;
   logic [OFF_W:0]    nbytes;
   logic [OFF_W-1:0]  off;
   logic [LINE_W-1:0] ld_lanes, st_data;
   logic [LINE_B-1:0] st_be;

   assign off = req_addr[OFF_W-1:0];

   vlf_decode #(.LANES(LANES), .LANE_W(LANE_W)) u_dec (
      .op(req_op), .kind(kind), .sext(sext), .is_store(is_store), .nbytes(nbytes)
   );

   vlf_unpack #(.LANES(LANES), .LANE_W(LANE_W)) u_unpack (
      .line(mem_line), .off(off), .kind(kind), .sext(sext), .lanes(ld_lanes)
   );

   vlf_pack #(.LANES(LANES), .LANE_W(LANE_W)) u_pack (
      .vreg(store_reg), .off(off), .kind(kind), .nbytes(nbytes),
      .wdata(st_data), .be(st_be)
   );

   assign mis = (kind != K_NONE) && (({1'b0, off} & (nbytes - 1'b1)) != '0);

   always_ff @(posedge clk) begin
      if (!rst_n || !req_valid || kind == K_NONE) begin
         out_valid    <= 1'b0;
         out_misalign <= 1'b0;
         out_lanes    <= '0;
         out_wdata    <= '0;
         out_be       <= '0;
      end else begin
         out_valid    <= 1'b1;
         out_misalign <= mis;
         out_lanes    <= (!is_store && !mis) ? ld_lanes : '0;
         out_wdata    <= ( is_store && !mis) ? st_data  : '0;
         out_be       <= ( is_store && !mis) ? st_be    : '0;
      end
   end

   // R2: a result only follows an accepted request
   p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(req_valid));

   // R2: idle outputs stay quiet
   p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_be == '0 && !out_misalign && out_lanes == '0 && out_wdata == '0));

   // R11: a trapped access moves no data
   p_misalign_blocks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      out_misalign |-> (out_be == '0 && out_lanes == '0 && out_wdata == '0));

   // R12: load lanes and store enables never appear together
   p_dir_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      out_be != '0 |-> out_lanes == '0);
endmodule

// File: tb/vlane_fmt_bench.sv
`timescale 1ns/1ps
module vlane_fmt_bench;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [5:0]   req_op = '0;
   logic [31:0]  req_addr = '0;
   logic [511:0] mem_line = '0;
   logic [511:0] store_reg = '0;
   logic         out_valid, out_misalign;
   logic [511:0] out_lanes, out_wdata;
   logic [63:0]  out_be;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk;

   vlane_fmt u_vlane_fmt (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .mem_line(mem_line), .store_reg(store_reg),
      .out_valid(out_valid), .out_misalign(out_misalign), .out_lanes(out_lanes),
      .out_wdata(out_wdata), .out_be(out_be)
   );

   task automatic check(input string req, input string what,
                        input logic [511:0] act, input logic [511:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive one request at a falling edge, result is read one falling edge later
   task automatic issue(input logic [5:0] op, input logic [31:0] addr);
      @(negedge clk);
      req_op    = op;
      req_addr  = addr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic check_load(input string req, input logic [511:0] exp);
      check(req, "valid", 512'(out_valid), 512'd1);
      check(req, "misalign", 512'(out_misalign), 512'd0);
      check(req, "lanes", out_lanes, exp);
      check("R12", "load be", 512'(out_be), 512'd0);
      check("R12", "load wdata", out_wdata, 512'd0);
   endtask

   task automatic check_store(input string req, input logic [511:0] expw,
                              input logic [63:0] expbe);
      check(req, "valid", 512'(out_valid), 512'd1);
      check(req, "misalign", 512'(out_misalign), 512'd0);
      check(req, "wdata", out_wdata, expw);
      check(req, "be", 512'(out_be), 512'(expbe));
      check("R12", "store lanes", out_lanes, 512'd0);
   endtask

   task automatic t_reset();
      check("R1", "valid", 512'(out_valid), 512'd0);
      check("R1", "be", 512'(out_be), 512'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "valid after release", 512'(out_valid), 512'd0);
      check("R1", "misalign", 512'(out_misalign), 512'd0);
      check("R1", "lanes", out_lanes | out_wdata, 512'd0);
   endtask

   task automatic t_bad_op(input logic [5:0] op);
      issue(op, 32'h0000_0000);
      check("R2", "unknown code valid", 512'(out_valid), 512'd0);
      check("R2", "unknown code be", 512'(out_be), 512'd0);
   endtask

   task automatic t_load_full();
      issue(6'd9, 32'h2000_0040);
      check_load("R3", mem_line);
      @(negedge clk);
      check("R2", "valid drops", 512'(out_valid), 512'd0);
   endtask

   task automatic t_load_byte(input bit s, input int off);
      logic [511:0] exp = '0;
      for (int i = 0; i < 16; i++) begin
         logic [7:0] b = mem_line[(off+i)*8 +: 8];
         exp[32*i +: 32] = s ? {{24{b[7]}}, b} : {24'd0, b};
      end
      issue(s ? 6'd7 : 6'd11, 32'h1000_0000 | 32'(off));
      check_load(s ? "R4" : "R5", exp);
   endtask

   task automatic t_load_half(input bit s, input int off);
      logic [511:0] exp = '0;
      for (int i = 0; i < 16; i++) begin
         logic [15:0] h = mem_line[(off+2*i)*8 +: 16];
         exp[32*i +: 32] = s ? {{16{h[15]}}, h} : {16'd0, h};
      end
      issue(s ? 6'd8 : 6'd12, 32'h1000_0000 | 32'(off));
      check_load("R6", exp);
   endtask

   task automatic t_load_w8(input int off);
      logic [511:0] exp = '0;
      for (int i = 0; i < 8; i++) exp[32*i +: 32] = mem_line[(off+4*i)*8 +: 32];
      issue(6'd13, 32'h3000_0000 | 32'(off));
      check_load("R7", exp);
   endtask

   task automatic t_store_byte(input int off);
      logic [511:0] expw = '0;
      logic [63:0]  expbe = '0;
      for (int i = 0; i < 16; i++) begin
         expw[(off+i)*8 +: 8] = store_reg[32*i +: 8];
         expbe[off+i] = 1'b1;
      end
      issue(6'd36, 32'h4000_0000 | 32'(off));
      check_store("R8", expw, expbe);
   endtask

   task automatic t_store_half(input int off);
      logic [511:0] expw = '0;
      logic [63:0]  expbe = '0;
      for (int i = 0; i < 16; i++) begin
         expw[(off+2*i)*8 +: 16] = store_reg[32*i +: 16];
         expbe[off+2*i]   = 1'b1;
         expbe[off+2*i+1] = 1'b1;
      end
      issue(6'd37, 32'h4000_0000 | 32'(off));
      check_store("R9", expw, expbe);
   endtask

   task automatic t_store_full();
      issue(6'd38, 32'h5000_0000);
      check_store("R10", store_reg, 64'hFFFF_FFFF_FFFF_FFFF);
   endtask

   task automatic t_misalign(input logic [5:0] op, input logic [31:0] addr);
      issue(op, addr);
      check("R11", "valid", 512'(out_valid), 512'd1);
      check("R11", "trap flag", 512'(out_misalign), 512'd1);
      check("R11", "no data", out_lanes | out_wdata, 512'd0);
      check("R11", "no be", 512'(out_be), 512'd0);
   endtask

   initial begin
      for (int k = 0; k < 64; k++) mem_line[8*k +: 8] = 8'(k * 29 + 131);
      for (int i = 0; i < 16; i++) store_reg[32*i +: 32] = 32'(i * 32'h1357_9BDF + 32'h80F0_7F81);
      repeat (3) @(negedge clk);
      t_reset();
      t_bad_op(6'd10);
      t_bad_op(6'd0);
      t_load_full();
      t_load_byte(1'b1, 16);
      t_load_byte(1'b1, 0);
      t_load_byte(1'b0, 48);
      t_load_half(1'b1, 32);
      t_load_half(1'b0, 0);
      t_load_w8(32);
      t_load_w8(0);
      t_store_byte(48);
      t_store_byte(0);
      t_store_half(32);
      t_store_full();
      t_misalign(6'd8, 32'h0000_0010);
      t_misalign(6'd36, 32'h0000_0004);
      t_misalign(6'd38, 32'h0000_0020);
      t_misalign(6'd9, 32'h0000_0001);
      @(negedge clk);
      check("R2", "quiet after trap", 512'(out_misalign), 512'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule